// File: doc/BRIEF.md
# Timer Clock Prescaler and Select

This block holds an 8-bit control register and a shared prescale counter. It produces one-cycle count-enable pulses for two timers. A host writes and reads the register through a write-enable, address and data interface. The prescale code chooses what the shared counter does: it can divide the system clock by 12, by 4 or by 48, or it can divide a synchronized external clock by 8.

Each timer has its own source bit. A source bit of 1 holds that timer's enable high on every cycle, which is the full system clock rate. A source bit of 0 makes the timer take the shared prescaled tick. When a timer's counter-mode input is high, its enable output simply follows that timer's event input, and the source bit has no effect. The outputs are clock enables, not derived clocks. The timers themselves sit outside this block.

Top module: `tmr_tick_gen`

## Requirements
- R1: After reset the register reads 0x00, and no enable pulse appears before the 12th cycle, counted from the reset release.
- R2: Register bits 7, 6, 5 and 2 always read 0, and writes to them are ignored. Writing 0xFF reads back as 0x1B.
- R3: The register layout is as follows. Bit 3 is the timer 0 source bit, bit 4 is the timer 1 source bit, and bits 1:0 are the prescale code. A read at the register address returns these stored bits.
- R4: A timer whose source bit is 1, and which is not in counter mode, has its enable held at 1 on every cycle.
- R5: With code 00, the prescaled tick is high for exactly one cycle in every 12.
- R6: With code 01, the prescaled tick is high for exactly one cycle in every 4.
- R7: With code 10, the prescaled tick is high for exactly one cycle in every 48.
- R8: With code 11, the tick is a single-cycle pulse on every 8th rising edge of the external clock. That clock passes through a two-flop synchronizer first.
- R9: While a timer's counter-mode input is 1, its enable equals its event input in the same cycle, whatever its source bit holds.
- R10: A write that changes the code clears the prescale counter. For a divide-by-N code, the first tick then appears in the cycle after the (N-1)th clock edge that follows the write edge. A tick that is due in the write cycle is still issued. A write that leaves the code unchanged does not disturb the phase of the counter.
- R11: The two timers share one prescaler. When both select the prescaled tick, their enables are identical in every cycle.
- R12: A write to any address other than the register address leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address, used for both read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; 0 when the address does not match |
| ext_clk_i | input | 1 | External clock, asynchronous |
| cnt_mode_i | input | 2 | Counter mode for each timer |
| evt_i | input | 2 | Event input for each timer, passed through in counter mode |
| en_o | output | 2 | Count enable for each timer |

## Verification
Two functions can fall in the same cycle: a prescaled tick coming due, and a register write that changes the code and clears the counter. The bench runs the divide-by-4 code until a tick is showing. In that same cycle it writes the divide-by-48 code. It then judges two things: that the tick in the write cycle is still present, and that the next tick arrives exactly 47 edges after the write edge. The bench also rewrites the current code in the middle of a period, to show that a write which changes nothing keeps the original phase.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned N_TMR    = 2;
  localparam int unsigned CODE_LSB = 0;
  localparam int unsigned SEL_LSB  = 3;

  typedef enum logic [1:0] {
    PS_DIV_A = 2'b00,
    PS_DIV_B = 2'b01,
    PS_DIV_C = 2'b10,
    PS_EXT   = 2'b11
  } ps_code_e;

  typedef struct packed {
    logic [N_TMR-1:0] sel;
    ps_code_e         code;
  } cfg_t;

  function automatic int unsigned cnt_bits(int unsigned a, int unsigned b,
                                           int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return (m < 2) ? 1 : $clog2(m);
  endfunction
endpackage

// File: rtl/tmr_tick_cfg.sv
module tmr_tick_cfg
  import tmr_tick_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output cfg_t              cfg_o,
  output logic              code_chg_o
);
  logic hit;
  logic wr_hit;
  cfg_t cfg_q, cfg_d;

  assign hit    = (addr_i == ADDR_W'(REG_ADDR));
  assign wr_hit = wr_en_i & hit;

  always_comb begin
    cfg_d.code = ps_code_e'(wdata_i[CODE_LSB +: 2]);
    for (int t = 0; t < N_TMR; t++) cfg_d.sel[t] = wdata_i[SEL_LSB + t];
  end

  // clear request only when the code really changes
  assign code_chg_o = wr_hit & (cfg_d.code != cfg_q.code);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_hit) cfg_q <= cfg_d;
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[CODE_LSB +: 2] = cfg_q.code;
      for (int t = 0; t < N_TMR; t++) rdata_o[SEL_LSB + t] = cfg_q.sel[t];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr_tick_presc.sv
module tmr_tick_presc
  import tmr_tick_pkg::*;
#(
  parameter int unsigned DIV_A   = 12,
  parameter int unsigned DIV_B   = 4,
  parameter int unsigned DIV_C   = 48,
  parameter int unsigned EXT_DIV = 8,
  parameter int unsigned CNT_W   = 6
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ps_code_e code_i,
  input  logic     clr_i,
  input  logic     ext_rise_i,
  output logic     tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             step;
  logic             at_lim;

  always_comb begin
    unique case (code_i)
      PS_DIV_A: lim = CNT_W'(DIV_A - 1);
      PS_DIV_B: lim = CNT_W'(DIV_B - 1);
      PS_DIV_C: lim = CNT_W'(DIV_C - 1);
      default:  lim = CNT_W'(EXT_DIV - 1);
    endcase
  end

  assign step   = (code_i == PS_EXT) ? ext_rise_i : 1'b1;
  assign at_lim = (cnt_q == lim);
  assign tick_o = step & at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (step) cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_tick_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned REG_ADDR    = 14,
  parameter int unsigned DIV_A       = 12,
  parameter int unsigned DIV_B       = 4,
  parameter int unsigned DIV_C       = 48,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              ext_clk_i,
  input  logic [1:0]        cnt_mode_i,
  input  logic [1:0]        evt_i,
  output logic [1:0]        en_o
);
  localparam int unsigned CNT_W = cnt_bits(DIV_A, DIV_B, DIV_C, EXT_DIV);

  cfg_t             cfg_w;
  logic             code_chg_w;
  logic             ext_rise_w;
  logic             pre_tick_w;
  logic [N_TMR-1:0] sel_w;

  tmr_tick_cfg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cfg_o      (cfg_w),
    .code_chg_o (code_chg_w)
  );

  tmr_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_clk_i),
    .rise_o  (ext_rise_w)
  );

  tmr_tick_presc #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C),
    .EXT_DIV(EXT_DIV), .CNT_W(CNT_W)
  ) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_i     (cfg_w.code),
    .clr_i      (code_chg_w),
    .ext_rise_i (ext_rise_w),
    .tick_o     (pre_tick_w)
  );

  assign sel_w = cfg_w.sel;

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    // counter mode wins, then system clock, then prescaled tick
    assign en_o[t] = cnt_mode_i[t] ? evt_i[t] : (sel_w[t] | pre_tick_w);
  end
endmodule

// File: rtl/tmr_tick_chk.sv
module tmr_tick_chk
  import tmr_tick_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       rdata_o,
  input logic [N_TMR-1:0] cnt_mode_i,
  input logic [N_TMR-1:0] evt_i,
  input logic [N_TMR-1:0] en_o,
  input logic [N_TMR-1:0] sel_i,
  input logic             code_chg_i,
  input logic             pre_tick_i
);
  assert_unused_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[7:5] == 3'b000) && (rdata_o[2] == 1'b0));

  assert_tick_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_tick_i |=> !pre_tick_i);

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_chg_i |=> !pre_tick_i);

  assert_shared_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_mode_i == '0 && sel_i == '0) |-> (en_o[0] == en_o[1]));

  for (genvar t = 0; t < N_TMR; t++) begin : g_chk
    assert_sys_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cnt_mode_i[t] && sel_i[t]) |-> en_o[t]);
    assert_cnt_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_mode_i[t] |-> (en_o[t] == evt_i[t]));
  end
endmodule

bind tmr_tick_gen tmr_tick_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rdata_o    (rdata_o),
  .cnt_mode_i (cnt_mode_i),
  .evt_i      (evt_i),
  .en_o       (en_o),
  .sel_i      (sel_w),
  .code_chg_i (code_chg_w),
  .pre_tick_i (pre_tick_w)
);

// File: tb/tmr_tick_gen_tb_top.sv
module tmr_tick_gen_tb_top;
  localparam logic [3:0] REG = 4'hE;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = REG;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ext_clk = 1'b0;
  logic [1:0] cnt_mode = '0;
  logic [1:0] evt = '0;
  logic [1:0] en;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_tick_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ext_clk_i(ext_clk),
    .cnt_mode_i(cnt_mode), .evt_i(evt), .en_o(en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = REG;
  endtask

  task automatic reg_rd(input logic [7:0] exp, input string req);
    addr = REG; #1;
    chk(rdata == exp, req, "readback", rdata, exp);
  endtask

  task automatic obs(input int n, input int j0, input int len,
                     input bit both, input string req);
    for (int c = 0; c < len; c++) begin
      int j = j0 + c;
      bit e = ((j % n) == (n - 1));
      chk(en[0] == e, req, "timer0 tick", en[0], e);
      if (both) chk(en[1] == en[0], "R11", "timer1 equals timer0", en[1], en[0]);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_rd(8'h00, "R1");
    chk(en == 2'b00, "R1", "enables at reset", en, 0);
    obs(12, 0, 30, 1'b1, "R1 R5");
  endtask

  task automatic t_reg_map;
    reg_wr(REG, 8'hFF);
    reg_rd(8'h1B, "R2");
    reg_wr(REG, 8'h08);
    reg_rd(8'h08, "R3");
    for (int i = 0; i < 6; i++) begin
      chk(en[0] == 1'b1, "R4", "timer0 system clock", en[0], 1);
      @(negedge clk);
    end
    reg_wr(REG, 8'h10);
    reg_rd(8'h10, "R3");
    reg_wr(4'h3, 8'hFF);
    reg_rd(8'h10, "R12");
    for (int i = 0; i < 6; i++) begin
      chk(en[1] == 1'b1, "R4", "timer1 system clock", en[1], 1);
      @(negedge clk);
    end
  endtask

  task automatic t_div4_coincide;
    reg_wr(REG, 8'h01);
    obs(4, 0, 20, 1'b1, "R6");
    reg_wr(REG, 8'h01);                 // same code, phase must continue
    obs(4, 21, 11, 1'b1, "R10");
    repeat (3) @(negedge clk);          // j = 35, tick due
    chk(en[0] == 1'b1, "R10", "tick in write cycle", en[0], 1);
    reg_wr(REG, 8'h02);
    obs(48, 0, 100, 1'b1, "R7");
  endtask

  task automatic t_div12;
    reg_wr(REG, 8'h00);
    obs(12, 0, 30, 1'b1, "R5");
  endtask

  task automatic t_ext;
    int  ticks = 0;
    bit  prev = 0;
    bit  dbl = 0;
    bit  t1_low = 0;
    ext_clk = 1'b0;
    reg_wr(REG, 8'h13);
    repeat (4) @(negedge clk);
    for (int r = 1; r <= 16; r++) begin
      for (int h = 0; h < 6; h++) begin
        ext_clk = (h < 3);
        @(negedge clk);
        if (en[0]) ticks++;
        if (en[0] && prev) dbl = 1;
        prev = en[0];
        if (!en[1]) t1_low = 1;
      end
      if (r == 7) chk(ticks == 0, "R8", "ticks after 7 edges", ticks, 0);
      if (r == 8) chk(ticks == 1, "R8", "ticks after 8 edges", ticks, 1);
    end
    chk(ticks == 2, "R8", "ticks after 16 edges", ticks, 2);
    chk(!dbl, "R8", "tick wider than one cycle", dbl, 0);
    chk(!t1_low, "R4", "timer1 dropped", t1_low, 0);
  endtask

  task automatic t_cnt_mode;
    reg_wr(REG, 8'h08);
    cnt_mode = 2'b11;
    for (int i = 0; i < 16; i++) begin
      evt = 2'(i ^ (i >> 2));
      #1;
      chk(en == evt, "R9", "counter mode passthrough", en, evt);
      @(negedge clk);
    end
    reg_wr(REG, 8'h00);
    cnt_mode = 2'b01;
    for (int i = 0; i < 16; i++) begin
      evt = 2'(i);
      #1;
      chk(en[0] == evt[0], "R9", "timer0 passthrough", en[0], evt[0]);
      @(negedge clk);
    end
    cnt_mode = 2'b00;
  endtask

  initial begin
    t_reset();
    t_reg_map();
    t_div4_coincide();
    t_div12();
    t_ext();
    t_cnt_mode();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule